// File: doc/BRIEF.md
# Two-Level Round-Robin Warp Fetch Scheduler

This block picks at most one warp per clock for instruction fetch out of `NUM_WARPS` warps. The warps are split into equal fetch groups of `GROUP_SIZE` consecutive IDs. One group holds top priority. The other groups rank after it in increasing group ID, wrapping around. Inside each group, warps are served round-robin from a pointer that belongs to that group.

A granted warp stays in flight until the pipeline returns a completion pulse for it. Until then it cannot be granted again, which gives barrel-style fetch. The top group hands priority to the next group when every warp in it reports a long-latency stall. It also hands over after a fixed number of issued instructions, so that no single group keeps priority forever. Instruction fetch, stall detection and memory lie outside the block.

Top module: `twl_warp_sched`

## Requirements
- R1: While reset is held and after its release, the top group is 0, no warp is in flight and every group pointer is at index 0. With no ready warp, `grant_valid_o` is 0.
- R2: A warp is eligible when its ready bit is 1, its stall bit is 0 and it is not in flight. A stalled or in-flight warp is never granted, even if it is ready. `grant_valid_o` is 1 exactly when some warp is eligible.
- R3: A granted warp becomes in flight at the clock edge that ends the grant cycle. A completion pulse for it clears that state at the next edge, and from the following cycle it can be granted again.
- R4: Within a group, the grant goes to the first eligible warp at or after the group's pointer, in increasing index order with wraparound. After a grant, the pointer moves to the granted index plus one, modulo `GROUP_SIZE`.
- R5: The grant comes from the first group, in the order top, top+1, ... modulo the group count, that has an eligible warp. If the top group has no eligible warp, the grant falls through to the next such group.
- R6: A group's pointer changes only in a cycle in which that group supplies the grant.
- R7: If the stall bits of all warps in the top group are 1, the top group advances by one, modulo the group count, at the next clock edge.
- R8: The top group also advances at the edge on which `issue_i` is sampled high for the `TIMEOUT`-th time since the last switch.
- R9: The issued-instruction count restarts from zero on every group switch, whether the switch came from a stall or from a timeout.
- R10: With a single group that covers all warps, the block acts as plain round-robin over all warps with barrel behaviour, and the top group stays 0.
- R11: The grant is combinational in the same cycle. `grant_id_o` equals group × `GROUP_SIZE` + index within the group, and it is 0 when there is no grant. `top_group_o` shows the current top group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | NUM_WARPS | Per-warp ready to fetch |
| stall_i | input | NUM_WARPS | Per-warp long-latency stall flag |
| done_i | input | NUM_WARPS | Per-warp completion pulse, clears in-flight state |
| issue_i | input | 1 | One instruction issued this cycle |
| grant_valid_o | output | 1 | A warp is granted this cycle |
| grant_id_o | output | max(1,clog2(NUM_WARPS)) | Granted warp ID |
| top_group_o | output | max(1,clog2(NUM_WARPS/GROUP_SIZE)) | Current top-priority group |

## Verification
The main instance has 12 warps in three groups of four and a timeout of 5 issues. With three groups, the bench sees the priority order wrap past the last group, sees fall-through skip a fully busy group, and sees several group switches within a few dozen cycles. A second instance has 6 warps in one group and a timeout of 3. Both instances get the same stimulus, so the single-group case can be compared with flat round-robin, including self-switches that must leave the top group at 0.

// File: rtl/twl_pkg.sv
package twl_pkg;

  // Return the first set bit of v[n-1:0] at or after start, wrapping; -1 if none.
  function automatic int rr_first(input logic [63:0] v, input int start, input int n);
    int res;
    res = -1;
    for (int j = 0; j < n; j++) begin
      if (res < 0 && v[(start + j) % n]) res = (start + j) % n;
    end
    return res;
  endfunction

  // Modular increment for indices and group numbers.
  function automatic int wrap_inc(input int x, input int n);
    return (x + 1 >= n) ? 0 : x + 1;
  endfunction

endpackage

// File: rtl/twl_grp_rr.sv
module twl_grp_rr #(
  parameter int GROUP_SIZE = 8,
  localparam int IW = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP_SIZE-1:0] elig,
  input  logic                  take,
  output logic                  any,
  output logic [IW-1:0]         pick
);
  logic [IW-1:0] ptr_q;
  int            pick_i;

  always_comb begin
    pick_i = twl_pkg::rr_first(64'(elig), int'(ptr_q), GROUP_SIZE);
    any    = (pick_i >= 0);
    pick   = (pick_i >= 0) ? IW'(pick_i) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (take) ptr_q <= IW'(twl_pkg::wrap_inc(int'(pick), GROUP_SIZE));
  end

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(ptr_q));
  assert_pick_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> elig[pick]);
  assert_any_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any == (|elig));
endmodule

// File: rtl/twl_grp_rotor.sv
module twl_grp_rotor #(
  parameter int NUM_GROUPS = 4,
  parameter int TIMEOUT    = 32768,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          top_stalled,
  input  logic          issue,
  output logic [GW-1:0] top,
  output logic          switch_now
);
  logic [CW-1:0] cnt_q;
  logic          tmo_hit;

  assign tmo_hit    = issue && (cnt_q == CW'(TIMEOUT - 1));
  assign switch_now = top_stalled || tmo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top   <= '0;
      cnt_q <= '0;
    end else if (switch_now) begin
      top   <= GW'(twl_pkg::wrap_inc(int'(top), NUM_GROUPS));
      cnt_q <= '0;
    end else if (issue) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(TIMEOUT));
  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    switch_now |=> cnt_q == '0);
  assert_top_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_now |=> $stable(top));
endmodule

// File: rtl/twl_warp_sched.sv
module twl_warp_sched #(
  parameter int NUM_WARPS  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int TIMEOUT    = 32768,
  localparam int NUM_GROUPS = NUM_WARPS / GROUP_SIZE,
  localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int IW = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] ready_i,
  input  logic [NUM_WARPS-1:0] stall_i,
  input  logic [NUM_WARPS-1:0] done_i,
  input  logic                 issue_i,
  output logic                 grant_valid_o,
  output logic [WW-1:0]        grant_id_o,
  output logic [GW-1:0]        top_group_o
);
  logic [NUM_WARPS-1:0]  busy_q;
  logic [NUM_WARPS-1:0]  elig;
  logic [NUM_WARPS-1:0]  grant_vec;
  logic [NUM_GROUPS-1:0] grp_any;
  logic [NUM_GROUPS-1:0] grp_stall;
  logic [NUM_GROUPS-1:0] grp_take;
  logic [IW-1:0]         grp_pick [NUM_GROUPS];
  logic [GW-1:0]         top_q;
  logic [GW-1:0]         win_grp;
  logic                  top_stalled;
  logic                  grp_switch;
  int                    win_i;

  assign elig = ready_i & ~stall_i & ~busy_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_stall[g] = &stall_i[g*GROUP_SIZE +: GROUP_SIZE];
    assign grp_take[g]  = grant_valid_o && (win_grp == GW'(g));
    twl_grp_rr #(.GROUP_SIZE(GROUP_SIZE)) i_rr (
      .clk  (clk),
      .rst_n(rst_n),
      .elig (elig[g*GROUP_SIZE +: GROUP_SIZE]),
      .take (grp_take[g]),
      .any  (grp_any[g]),
      .pick (grp_pick[g])
    );
  end

  always_comb begin
    win_i         = twl_pkg::rr_first(64'(grp_any), int'(top_q), NUM_GROUPS);
    grant_valid_o = (win_i >= 0);
    win_grp       = (win_i >= 0) ? GW'(win_i) : '0;
    grant_id_o    = grant_valid_o
                  ? WW'(int'(win_grp) * GROUP_SIZE + int'(grp_pick[win_grp])) : '0;
    grant_vec     = grant_valid_o ? (NUM_WARPS'(1) << grant_id_o) : '0;
    top_stalled   = grp_stall[top_q];
  end

  twl_grp_rotor #(.NUM_GROUPS(NUM_GROUPS), .TIMEOUT(TIMEOUT)) i_rotor (
    .clk        (clk),
    .rst_n      (rst_n),
    .top_stalled(top_stalled),
    .issue      (issue_i),
    .top        (top_q),
    .switch_now (grp_switch)
  );

  assign top_group_o = top_q;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~done_i) | grant_vec;
  end

  assert_no_regrant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> !busy_q[grant_id_o] && ready_i[grant_id_o] && !stall_i[grant_id_o]);
  assert_marks_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |=> busy_q[$past(grant_id_o)]);
  assert_top_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o && grp_any[top_q] |-> (int'(grant_id_o) / GROUP_SIZE) == int'(top_q));
  assert_one_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_take));
  assert_stall_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    top_stalled |=> top_q == GW'(twl_pkg::wrap_inc(int'($past(top_q)), NUM_GROUPS)));
endmodule

// File: tb/test_twl_warp_sched.sv
module test_twl_warp_sched;
  localparam int M0 = 12, G0 = 4, T0 = 5;
  localparam int M1 = 6,  G1 = 6, T1 = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n;

  logic [11:0] rdy0, stl0, dn0;
  logic        iss0;
  logic [5:0]  rdy1, stl1, dn1;
  logic        iss1;
  logic        v0, v1;
  logic [3:0]  id0;
  logic [1:0]  top0;
  logic [2:0]  id1;
  logic [0:0]  top1;

  twl_warp_sched #(.NUM_WARPS(M0), .GROUP_SIZE(G0), .TIMEOUT(T0)) i_twl_warp_sched (
    .clk(clk), .rst_n(rst_n), .ready_i(rdy0), .stall_i(stl0), .done_i(dn0),
    .issue_i(iss0), .grant_valid_o(v0), .grant_id_o(id0), .top_group_o(top0));

  twl_warp_sched #(.NUM_WARPS(M1), .GROUP_SIZE(G1), .TIMEOUT(T1)) i_flat (
    .clk(clk), .rst_n(rst_n), .ready_i(rdy1), .stall_i(stl1), .done_i(dn1),
    .issue_i(iss1), .grant_valid_o(v1), .grant_id_o(id1), .top_group_o(top1));

  int n_chk = 0, n_fail = 0;

  // reference state, indexed by unit (0 = grouped, 1 = single group)
  int mm[2] = '{M0, M1};
  int mg[2] = '{G0, G1};
  int mt[2] = '{T0, T1};
  bit mbusy[2][12];
  int mptr[2][3];
  int mtop[2];
  int mcnt[2];

  int    q_u[$], q_v[$], q_id[$], q_top[$];
  string q_tag[$];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(int u, logic [11:0] r, logic [11:0] s, logic [11:0] d, logic iss, string tag);
    int ng, gv, gid, gg, gi, g, i, w;
    bit all_st;
    ng = mm[u] / mg[u];
    gv = 0; gid = 0; gg = 0; gi = 0;
    for (int k = 0; k < ng; k++) begin
      g = (mtop[u] + k) % ng;
      for (int j = 0; j < mg[u]; j++) begin
        i = (mptr[u][g] + j) % mg[u];
        w = g * mg[u] + i;
        if (gv == 0 && r[w] && !s[w] && !mbusy[u][w]) begin
          gv = 1; gid = w; gg = g; gi = i;
        end
      end
    end
    q_u.push_back(u); q_v.push_back(gv); q_id.push_back(gid);
    q_top.push_back(mtop[u]); q_tag.push_back(tag);
    for (int k = 0; k < mm[u]; k++) if (d[k]) mbusy[u][k] = 0;
    if (gv != 0) begin
      mbusy[u][gid] = 1;
      mptr[u][gg] = (gi + 1) % mg[u];
    end
    all_st = 1;
    for (int k = 0; k < mg[u]; k++) if (!s[mtop[u] * mg[u] + k]) all_st = 0;
    if (all_st || (iss && mcnt[u] == mt[u] - 1)) begin
      mtop[u] = (mtop[u] + 1) % ng;
      mcnt[u] = 0;
    end else if (iss) begin
      mcnt[u]++;
    end
  endtask

  task automatic step(logic [11:0] r, logic [11:0] s, logic [11:0] d, logic iss, string tag);
    @(negedge clk);
    rdy0 = r; stl0 = s; dn0 = d; iss0 = iss;
    rdy1 = r[5:0]; stl1 = s[5:0]; dn1 = d[5:0]; iss1 = iss;
    model(0, r, s, d, iss, tag);
    model(1, r, s, d, iss, {"R10 ", tag});
  endtask

  // monitor: compare each expected item with the ports just before the edge
  always @(negedge clk) begin
    #1;
    while (q_u.size() > 0) begin
      int u, ev, eid, et;
      string tg;
      u = q_u.pop_front(); ev = q_v.pop_front(); eid = q_id.pop_front();
      et = q_top.pop_front(); tg = q_tag.pop_front();
      if (u == 0) begin
        check({tg, " valid"}, int'(v0), ev);
        if (ev != 0) check({tg, " id"}, int'(id0), eid);
        else         check({tg, " R11 idle id"}, int'(id0), 0);
        check({tg, " top"}, int'(top0), et);
      end else begin
        check({tg, " valid"}, int'(v1), ev);
        if (ev != 0) check({tg, " id"}, int'(id1), eid);
        check({tg, " top"}, int'(top1), et);
      end
    end
  end

  bit finished = 0;

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rdy0 = '0; stl0 = '0; dn0 = '0; iss0 = 0;
    rdy1 = '0; stl1 = '0; dn1 = '0; iss1 = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset valid", int'(v0), 0);
    check("R1 reset top", int'(top0), 0);
    check("R1 reset flat valid", int'(v1), 0);
    @(negedge clk); rst_n = 1;

    // R4/R11: in-group order from pointer 0; R5: fall-through once group 0 busy
    for (int k = 0; k < 6; k++) step(12'hfff, '0, '0, 0, "R4 R5 R11 fill");
    // R3: done of warps 1,2 takes effect after the edge
    step(12'hfff, '0, 12'h006, 0, "R3 done edge");
    step(12'hfff, '0, '0, 0, "R3 R4 regrant");
    step(12'hfff, '0, '0, 0, "R3 R4 regrant");
    // R2: stall masks ready idle warps
    step(12'hfff, 12'hfff, 12'hfff, 0, "R2 R7 all stalled");
    step(12'hfff, 12'h0f0, '0, 0, "R2 R7 stall group");
    step(12'hfff, 12'h0f0, '0, 0, "R2 R6 partial");
    step(12'h000, '0, 12'hfff, 0, "R1 R2 idle");
    // R8: timeout on the fifth issue
    for (int k = 0; k < 5; k++) step('0, '0, '0, 1, "R8 timeout");
    // R9: stall switch, then count restarts
    step('0, 12'hfff, '0, 1, "R7 R9 stall switch");
    for (int k = 0; k < 6; k++) step('0, '0, '0, 1, "R9 recount");
    // R6: other groups keep their pointers across many grants
    for (int k = 0; k < 10; k++) step(12'hfff, '0, 12'hfff, 0, "R4 R6 rotate");
    for (int k = 0; k < 8; k++) step(12'ha5c, 12'h100, (k % 2 == 0) ? 12'h0f0 : 12'h30f, 1,
                                     "R5 R6 R8 mixed");
    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule